// File: doc/BRIEF.md
# Programmable Reference Rate Divider

This block divides a reference clock down to a phase-comparison rate. It counts reference cycles and raises a single-cycle strobe on `cmp_strobe` once in every `div_setting + 1` cycles. Logic downstream treats the strobe as the comparison-rate enable. A setting of zero does not stall the divider. Instead it passes the reference straight through, and the strobe stays high on every cycle.

A narrow mode limits the setting to its low four bits. When `narrow_mode` is high, bits 5 and 4 of `div_setting` are treated as zero. The divider samples a new setting only at a terminal count, so a reprogramming never shortens or stretches the period already in progress. The asynchronous active-low reset passes through a two-stage synchroniser, which releases the core on a clock edge.

Top module: `ref_rate_divider`

## Requirements
- R1: Once running, `cmp_strobe` is high once every P cycles, where P = S + 1 and S is the effective setting (0..63).
- R2: When P is greater than 1, each strobe is exactly one clock cycle wide.
- R3: When the effective setting is 0, `cmp_strobe` is high on every cycle, so the reference passes straight through.
- R4: While `narrow_mode` is 1, bits 5 and 4 of `div_setting` are forced to 0. The effective setting is then `div_setting[3:0]` and P is at most 16. While `narrow_mode` is 0, all six bits are used.
- R5: A change to `div_setting` or `narrow_mode` takes effect only at the next terminal count. The period in progress completes with its old length, and the next period uses the new value.
- R6: While `rst_n` is low, `cmp_strobe` is 0. After `rst_n` rises, the first strobe appears 2 + P clock edges later. Two of those edges belong to the reset synchroniser, and P is the period in effect at release.
- R7: The internal cycle counter never exceeds the active period setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally |
| div_setting | input | 6 | Division setting S; the period is S + 1 cycles |
| narrow_mode | input | 1 | When 1, bits 5 and 4 of the setting are forced to 0 |
| cmp_strobe | output | 1 | Comparison-rate strobe, one cycle high per period |

## Verification
The assertions check these rules on every cycle:
- the counter stays within the active period;
- the period register holds between terminal counts;
- the strobe is one cycle wide when P exceeds 1, and stays high when P is 1;
- the masked upper bits stay clear under narrow mode;
- the strobe stays low during reset.

Only the bench scenarios can show that the spacing between strobes equals the programmed period. The same applies to the first-strobe delay after reset release and to a mid-period change showing up one full period late.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  // Width of the division setting and of the cycle counter.
  localparam int unsigned DIV_W_DEF = 6;
  // Setting bits at and above this index are cleared in narrow mode.
  localparam int unsigned NARROW_KEEP_DEF = 4;
  // Flops in the reset-release synchroniser.
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int unsigned STAGES = ref_div_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/setting_mask.sv
module setting_mask #(
  parameter int unsigned W    = ref_div_pkg::DIV_W_DEF,
  parameter int unsigned KEEP = ref_div_pkg::NARROW_KEEP_DEF
) (
  input  logic [W-1:0] raw,
  input  logic         narrow,
  output logic [W-1:0] eff
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < KEEP) begin : g_keep
      assign eff[i] = raw[i];
    end else begin : g_clear
      assign eff[i] = raw[i] & ~narrow;
    end
  end
endmodule

// File: rtl/rate_counter.sv
module rate_counter #(
  parameter int unsigned W = ref_div_pkg::DIV_W_DEF
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] setting,
  output logic         strobe
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, per_d;
  logic         armed_q, armed_d;
  logic         stb_q, stb_d;
  logic [W-1:0] limit;
  logic         term;

  // Before the first period is armed, the live setting defines it.
  always_comb begin
    limit   = armed_q ? per_q : setting;
    term    = (cnt_q == limit);
    cnt_d   = term ? '0 : cnt_q + 1'b1;
    per_d   = (term || !armed_q) ? setting : per_q;
    armed_d = 1'b1;
    stb_d   = term;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      armed_q <= armed_d;
      stb_q   <= stb_d;
    end
  end

  assign strobe = stb_q;
endmodule

// File: rtl/ref_rate_divider.sv
module ref_rate_divider #(
  parameter int unsigned DIV_W       = ref_div_pkg::DIV_W_DEF,
  parameter int unsigned NARROW_KEEP = ref_div_pkg::NARROW_KEEP_DEF,
  parameter int unsigned SYNC_STAGES = ref_div_pkg::SYNC_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_setting,
  input  logic             narrow_mode,
  output logic             cmp_strobe
);
  logic             core_rst_n;
  logic [DIV_W-1:0] eff_setting;

  rst_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (core_rst_n)
  );

  setting_mask #(.W(DIV_W), .KEEP(NARROW_KEEP)) u_mask (
    .raw    (div_setting),
    .narrow (narrow_mode),
    .eff    (eff_setting)
  );

  rate_counter #(.W(DIV_W)) u_count (
    .clk     (clk),
    .srst_n  (core_rst_n),
    .setting (eff_setting),
    .strobe  (cmp_strobe)
  );
endmodule

// File: rtl/ref_rate_divider_chk.sv
module ref_rate_divider_chk #(
  parameter int unsigned DIV_W       = 6,
  parameter int unsigned NARROW_KEEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             narrow_mode,
  input logic             cmp_strobe,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] per,
  input logic             armed
);
  // R7
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt <= per));

  // R5
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (cnt != per)) |=> (per == $past(per)));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe && (per != '0)) |=> !cmp_strobe);

  // R3
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe && (per == '0)) |=> cmp_strobe);

  // R4
  narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe && $past(narrow_mode)) |-> ((per >> NARROW_KEEP) == '0));

  // R6
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !cmp_strobe);
endmodule

bind ref_rate_divider ref_rate_divider_chk #(
  .DIV_W       (DIV_W),
  .NARROW_KEEP (NARROW_KEEP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .narrow_mode (narrow_mode),
  .cmp_strobe  (cmp_strobe),
  .cnt         (u_count.cnt_q),
  .per         (u_count.per_q),
  .armed       (u_count.armed_q)
);

// File: tb/sim_ref_rate_divider.sv
`timescale 1ns/1ps
module sim_ref_rate_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] div_setting = 6'd0;
  logic       narrow_mode = 1'b0;
  logic       cmp_strobe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ref_rate_divider u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_setting (div_setting),
    .narrow_mode (narrow_mode),
    .cmp_strobe  (cmp_strobe)
  );

  function automatic int exp_period(input logic [5:0] s, input logic nm);
    return nm ? (int'(s[3:0]) + 1) : (int'(s) + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts falling edges until the strobe is seen high; 0 means timeout.
  task automatic wait_strobe(output int n);
    n = 0;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (cmp_strobe) begin
        n = k;
        return;
      end
    end
  endtask

  // Applies a reset with the given setting and checks quiet and first strobe.
  task automatic reset_with(input logic [5:0] s, input logic nm, input string tag);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    div_setting = s;
    narrow_mode = nm;
    repeat (3) @(negedge clk);
    check(cmp_strobe == 1'b0, "R6 quiet in reset", int'(cmp_strobe), 0);
    rst_n = 1'b1;
    wait_strobe(n);
    check(n == exp_period(s, nm) + 2, tag, n, exp_period(s, nm) + 2);
  endtask

  // Measures several gaps; caller must be at a negedge right after a strobe.
  task automatic check_gaps(input int p, input int reps, input string tag);
    int n;
    for (int i = 0; i < reps; i++) begin
      wait_strobe(n);
      check(n == p, tag, n, p);
    end
  endtask

  // Changes the setting just after a strobe; old period must complete first.
  task automatic change_setting(input logic [5:0] s, input logic nm);
    int n;
    int p_old;
    int p_new;
    p_old = exp_period(div_setting, narrow_mode);
    p_new = exp_period(s, nm);
    div_setting = s;
    narrow_mode = nm;
    wait_strobe(n);
    check(n == p_old, "R5 old period completes", n, p_old);
    wait_strobe(n);
    check(n == p_new, "R5 new period applied", n, p_new);
  endtask

  initial begin
    int n;
    logic [5:0] s;
    logic nm;
    void'($urandom(32'h5EED_0042));

    // R6: first strobe after release, then R1 spacing
    reset_with(6'd5, 1'b0, "R6 first strobe delay");
    check_gaps(6, 3, "R1 period S=5");

    // R2: strobe one cycle wide
    @(negedge clk);
    check(cmp_strobe == 1'b0, "R2 pulse width", int'(cmp_strobe), 0);
    wait_strobe(n);

    // R3: zero setting passes the reference through
    reset_with(6'd0, 1'b0, "R6 first strobe S=0");
    check_gaps(1, 5, "R3 passthrough");

    // R1: full-scale setting
    reset_with(6'd63, 1'b0, "R6 first strobe S=63");
    check_gaps(64, 2, "R1 period S=63");

    // R4: narrow mode masks bits 5 and 4
    reset_with(6'd63, 1'b1, "R6 first strobe narrow");
    check_gaps(16, 2, "R4 narrow S=63 -> 16");
    change_setting(6'h30, 1'b1);
    check_gaps(1, 3, "R4 narrow S=0x30 -> passthrough");
    change_setting(6'h30, 1'b0);
    check_gaps(49, 1, "R4 wide S=0x30 -> 49");

    // R5: change from long to short and short to long
    change_setting(6'd2, 1'b0);
    change_setting(6'd40, 1'b0);
    change_setting(6'd0, 1'b0);

    // Random settings with mid-period changes
    for (int i = 0; i < 20; i++) begin
      s  = 6'($urandom_range(0, 63));
      nm = 1'($urandom_range(0, 1));
      if (i % 5 == 0) begin
        reset_with(s, nm, "R6 random first strobe");
      end else begin
        change_setting(s, nm);
      end
      check_gaps(exp_period(s, nm), 2, "R1 random period");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule